// File: doc/BRIEF.md
# Flash Status and Erase Timer

This block holds the status byte that software polls while a parallel NOR flash array runs an embedded program or erase, and it models erase time with a cycle counter. The command sequencer reports three kinds of event. A finished program arrives with bit 7 of the data that was written. An erase start arrives tagged as a whole-chip or a single-sector erase. A status read arrives as a one-cycle strobe. The block updates the status byte from these events.

During data polling, bit 7 shows the complement of the written data. It flips once when an erase finishes. Bit 6 inverts after every status read, so software that reads twice can tell whether an operation is still running. Erase time is expressed through a ticks-per-second parameter: a sector erase lasts half a second of modelled time and a chip erase lasts five seconds. When the count runs out, the block raises a registered one-cycle `done_o` pulse. The sequencer uses this pulse to return to idle, or to the bypass state.

Top module: `flash_status_timer`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets status_o to 8'h00, holds done_o low and stops any running erase count, so no done_o pulse follows until a new erase start.
- R2: A program-complete event (prog_done_i high with no erase start) loads status_o at the next edge with bit 7 = NOT prog_d7_i and bits 6..0 = 7'h7F, giving 8'h7F for a written bit of 1 and 8'hFF for 0. It overrides an erase expiry at the same edge and never causes a done_o pulse.
- R3: A status read (status_rd_i high with no erase start and no program event) leaves status_o unchanged during the read cycle and inverts bit 6 at the following edge. Bits 5..0 are unchanged.
- R4: An erase start (erase_start_i high) clears status_o to 8'h00 at the next edge. It takes priority over a program event and a status read in the same cycle.
- R5: A sector erase (erase_chip_i = 0) raises done_o exactly SECTOR_CYCLES = TICKS_PER_SEC/2 clock edges after the edge that samples the start. Bit 7 of status_o inverts at that same edge.
- R6: A chip erase (erase_chip_i = 1) does the same after CHIP_CYCLES = 5*TICKS_PER_SEC edges.
- R7: done_o is registered, high for exactly one cycle, and high only at the expiry of an erase count.
- R8: An erase start while a count is running restarts the count with the duration of the new erase kind. Only one done_o pulse follows, timed from the last start.
- R9: If a status read coincides with the expiry edge, bit 7 and bit 6 both invert at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_done_i | input | 1 | One-cycle event: a program operation completed |
| prog_d7_i | input | 1 | Bit 7 of the data written by that program operation |
| erase_start_i | input | 1 | One-cycle event: an erase begins |
| erase_chip_i | input | 1 | Erase kind with erase_start_i: 1 = whole chip, 0 = one sector |
| status_rd_i | input | 1 | One-cycle strobe: software reads the status byte |
| status_o | output | 8 | Current status byte |
| done_o | output | 1 | One-cycle pulse when an erase count expires |

## Verification
The hardest situations to reach are events that land on the exact expiry edge: a status read there, or a fresh erase start there, which must cancel the pending pulse. Random stimulus seldom hits a single edge out of hundreds. The bench therefore counts cycles from the start event and places the read, or the restart, on the computed final cycle. A seeded random phase with short erase durations then mixes every event kind against a cycle-accurate model built from the requirements.

// File: rtl/flash_stat_pkg.sv
// Shared definitions for the flash status and erase timer block.
// Assumes an 8-bit status byte whose polling bits sit at positions 7 and 6.
package flash_stat_pkg;

    localparam int STAT_W   = 8;
    localparam int POLL_BIT = 7;
    localparam int TOGL_BIT = 6;

    typedef enum logic {
        ERASE_SECTOR = 1'b0,
        ERASE_CHIP   = 1'b1
    } erase_kind_e;

    // Status image after a finished program: bit 7 inverted, all others set.
    function automatic logic [STAT_W-1:0] prog_image(input logic d7);
        logic [STAT_W-1:0] img;
        img           = '1;
        img[POLL_BIT] = ~d7;
        return img;
    endfunction

endpackage

// File: rtl/flash_erase_timer.sv
// Erase busy counter. Loads a cycle count on an erase start (which also
// restarts a running count), counts down, and flags the expiry edge both
// combinationally (expire_o) and as a registered one-cycle done pulse.
// Assumes both durations are at least one cycle.
module flash_erase_timer
    import flash_stat_pkg::*;
#(
    parameter int SECTOR_CYCLES = 500,
    parameter int CHIP_CYCLES   = 5000,
    localparam int MAX_CYCLES   = (CHIP_CYCLES > SECTOR_CYCLES) ? CHIP_CYCLES : SECTOR_CYCLES,
    localparam int CW           = $clog2(MAX_CYCLES + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  erase_kind_e kind_i,
    output logic        expire_o,
    output logic        done_o
);

    localparam logic [CW-1:0] SECTOR_LD = CW'(SECTOR_CYCLES);
    localparam logic [CW-1:0] CHIP_LD   = CW'(CHIP_CYCLES);
    localparam logic [CW-1:0] LAST      = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    // Expiry: running, on the final count, and not overridden by a restart.
    always_comb begin
        expire_o = run_q && (cnt_q == LAST) && !start_i;
    end

    // Count state and registered done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= expire_o;
            if (start_i) begin
                cnt_q <= (kind_i == ERASE_CHIP) ? CHIP_LD : SECTOR_LD;
                run_q <= 1'b1;
            end else if (expire_o) begin
                cnt_q <= '0;
                run_q <= 1'b0;
            end else if (run_q) begin
                cnt_q <= cnt_q - LAST;
            end
        end
    end

endmodule

// File: rtl/flash_status_byte.sv
// Status byte register. Priority at each edge: clear, then program load,
// then the independent bit-7 flip (erase expiry) and bit-6 flip (read).
// Assumes the events arrive as single-cycle strobes.
module flash_status_byte
    import flash_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              prog_i,
    input  logic              prog_d7_i,
    input  logic              read_i,
    input  logic              expire_i,
    output logic [STAT_W-1:0] status_o
);

    logic [STAT_W-1:0] flip_mask;

    // Bits to invert when no clear or load is pending.
    always_comb begin
        flip_mask           = '0;
        flip_mask[POLL_BIT] = expire_i;
        flip_mask[TOGL_BIT] = read_i;
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
        end else if (clear_i) begin
            status_o <= '0;
        end else if (prog_i) begin
            status_o <= prog_image(prog_d7_i);
        end else begin
            status_o <= status_o ^ flip_mask;
        end
    end

endmodule

// File: rtl/flash_status_timer.sv
// Top of the flash status and erase timer. Derives the two erase durations
// from a ticks-per-second parameter and joins the counter and status byte.
// Assumes TICKS_PER_SEC >= 2 so that a sector erase lasts at least one cycle.
module flash_status_timer
    import flash_stat_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_done_i,
    input  logic              prog_d7_i,
    input  logic              erase_start_i,
    input  logic              erase_chip_i,
    input  logic              status_rd_i,
    output logic [STAT_W-1:0] status_o,
    output logic              done_o
);

    localparam int SECTOR_CYCLES = TICKS_PER_SEC / 2;
    localparam int CHIP_CYCLES   = TICKS_PER_SEC * 5;

    logic        expire;
    erase_kind_e kind;

    // Map the raw kind bit onto the package type.
    always_comb begin
        kind = erase_kind_e'(erase_chip_i);
    end

    flash_erase_timer #(
        .SECTOR_CYCLES (SECTOR_CYCLES),
        .CHIP_CYCLES   (CHIP_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (erase_start_i),
        .kind_i   (kind),
        .expire_o (expire),
        .done_o   (done_o)
    );

    flash_status_byte u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (erase_start_i),
        .prog_i    (prog_done_i),
        .prog_d7_i (prog_d7_i),
        .read_i    (status_rd_i),
        .expire_i  (expire),
        .status_o  (status_o)
    );

endmodule

// File: rtl/flash_status_timer_chk.sv
// Property checker for flash_status_timer, attached by bind below.
// Assumes both erase durations exceed one cycle.
module flash_status_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       prog_done_i,
    input logic       prog_d7_i,
    input logic       erase_start_i,
    input logic       status_rd_i,
    input logic [7:0] status_o,
    input logic       done_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (status_o == 8'h00 && !done_o));

    // R2
    prog_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_done_i && !erase_start_i) |=>
            (status_o[7] == !$past(prog_d7_i) && status_o[6:0] == 7'h7F));

    // R3
    read_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd_i && !erase_start_i && !prog_done_i) |=>
            (status_o[6] != $past(status_o[6]) && $stable(status_o[5:0])));

    // R4
    erase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start_i |=> (status_o == 8'h00));

    // R7
    done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    done_flips_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(rst_n) && !$past(prog_done_i) && !$past(erase_start_i))
            |-> (status_o[7] != $past(status_o[7])));

endmodule

bind flash_status_timer flash_status_timer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .prog_done_i   (prog_done_i),
    .prog_d7_i     (prog_d7_i),
    .erase_start_i (erase_start_i),
    .status_rd_i   (status_rd_i),
    .status_o      (status_o),
    .done_o        (done_o)
);

// File: tb/flash_status_timer_bench.sv
module flash_status_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 40;
    localparam int SECT       = TPS / 2;
    localparam int CHIP       = TPS * 5;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_done = 1'b0, prog_d7 = 1'b0, erase_start = 1'b0;
    logic       erase_chip = 1'b0, status_rd = 1'b0;
    logic [7:0] status;
    logic       done;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";

    // Reference state computed from the requirements.
    logic [7:0] m_stat = 8'h00;
    logic       m_done = 1'b0;
    logic       m_run  = 1'b0;
    int         m_cnt  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_timer #(.TICKS_PER_SEC(TPS)) u_flash_status_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .prog_done_i   (prog_done),
        .prog_d7_i     (prog_d7),
        .erase_start_i (erase_start),
        .erase_chip_i  (erase_chip),
        .status_rd_i   (status_rd),
        .status_o      (status),
        .done_o        (done)
    );

    function automatic logic [7:0] prog_val(input logic d7);
        return d7 ? 8'h7F : 8'hFF;
    endfunction

    task automatic model_edge();
        logic expire;
        expire = 1'b0;
        if (!rst_n) begin
            m_stat = 8'h00; m_done = 1'b0; m_run = 1'b0; m_cnt = 0;
        end else begin
            if (erase_start) begin
                m_run = 1'b1; m_cnt = erase_chip ? CHIP : SECT;
            end else if (m_run) begin
                if (m_cnt == 1) begin m_run = 1'b0; expire = 1'b1; end
                else m_cnt = m_cnt - 1;
            end
            m_done = expire;
            if (erase_start)    m_stat = 8'h00;
            else if (prog_done) m_stat = prog_val(prog_d7);
            else begin
                if (expire)    m_stat[7] = ~m_stat[7];
                if (status_rd) m_stat[6] = ~m_stat[6];
            end
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, model the rising edge, compare after it.
    task automatic step(input logic st, input logic ch, input logic pr, input logic d7, input logic rd);
        erase_start = st; erase_chip = ch; prog_done = pr; prog_d7 = d7; status_rd = rd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(status == m_stat && done == m_done, cur_req, {done, status}, {m_done, m_stat});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual expired expected finished");
        summary();
    end

    initial begin
        int k;
        @(negedge clk);
        rst_n = 1'b0;
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        // R1 reset state
        cur_req = "R1";
        check(status == 8'h00 && !done, "R1", {done, status}, 9'h000);
        rst_n = 1'b1;

        // R2 program image for both data bits
        cur_req = "R2";
        step(0, 0, 1, 1, 0);
        check(status == 8'h7F, "R2", {1'b0, status}, 9'h07F);
        step(0, 0, 1, 0, 0);
        check(status == 8'hFF && !done, "R2", {done, status}, 9'h0FF);

        // R3 read toggles bit 6 after the read
        cur_req = "R3";
        status_rd = 1'b1;
        check(status == 8'hFF, "R3", {1'b0, status}, 9'h0FF);
        step(0, 0, 0, 0, 1);
        check(status == 8'hBF, "R3", {1'b0, status}, 9'h0BF);
        step(0, 0, 0, 0, 1);
        check(status == 8'hFF, "R3", {1'b0, status}, 9'h0FF);

        // R4 erase start wins over program and read
        cur_req = "R4";
        step(1, 0, 1, 0, 1);
        check(status == 8'h00, "R4", {1'b0, status}, 9'h000);

        // R5 sector duration counted from that start
        cur_req = "R5";
        k = 0;
        while (!done && k < CHIP + 10) begin idle(1); k++; end
        check(k == SECT, "R5", 9'(k), 9'(SECT));
        check(status == 8'h80, "R5", {1'b0, status}, 9'h080);
        // R7 one cycle wide
        idle(1);
        check(!done, "R7", {8'h0, done}, 9'h000);

        // R6 chip duration
        cur_req = "R6";
        step(1, 1, 0, 0, 0);
        k = 0;
        while (!done && k < CHIP + 10) begin idle(1); k++; end
        check(k == CHIP, "R6", 9'(k), 9'(CHIP));

        // R8 restart mid-count, and restart on the final count
        cur_req = "R8";
        step(1, 0, 0, 0, 0);
        idle(10);
        step(1, 1, 0, 0, 0);
        k = 0;
        while (!done && k < CHIP + 10) begin idle(1); k++; end
        check(k == CHIP, "R8", 9'(k), 9'(CHIP));
        step(1, 0, 0, 0, 0);
        idle(SECT - 1);
        step(1, 0, 0, 0, 0);
        check(!done, "R8", {8'h0, done}, 9'h000);
        k = 0;
        while (!done && k < CHIP + 10) begin idle(1); k++; end
        check(k == SECT, "R8", 9'(k), 9'(SECT));

        // R9 read on the expiry edge flips both bits
        cur_req = "R9";
        step(1, 0, 0, 0, 0);
        idle(SECT - 1);
        step(0, 0, 0, 0, 1);
        check(done && status == 8'hC0, "R9", {done, status}, 9'h1C0);

        // R2 program on the expiry edge overrides the flip
        cur_req = "R2";
        step(1, 0, 0, 0, 0);
        idle(SECT - 1);
        step(0, 0, 1, 1, 0);
        check(done && status == 8'h7F, "R2", {done, status}, 9'h17F);

        // R1 reset mid-erase stops the count
        cur_req = "R1";
        step(1, 1, 0, 0, 0);
        idle(5);
        rst_n = 1'b0;
        step(0, 0, 0, 0, 0);
        rst_n = 1'b1;
        k = 0;
        for (int i = 0; i < CHIP + 5; i++) begin idle(1); if (done) k++; end
        check(k == 0 && status == 8'h00, "R1", {k[0], status}, 9'h000);

        // Seeded random mix checked against the model every cycle
        cur_req = "R2/R3/R4/R5/R6/R8/R9 random";
        void'($urandom(32'h5EED_F1A5));
        for (int i = 0; i < 8000; i++) begin
            logic st, pr, rd;
            st = ($urandom % 100) < 2;
            pr = ($urandom % 100) < 5;
            rd = ($urandom % 100) < 30;
            step(st, 1'($urandom % 4 == 0), pr, 1'($urandom), rd);
        end
        idle(1);
        summary();
    end

endmodule